// File: doc/BRIEF.md
# Multiply-Accumulate/Subtract Execution Unit

This unit is the integer multiply stage of a processor datapath. It takes two W-bit multiplicands and an accumulator operand. It forms one of three results: the plain product, the product plus the accumulator, or the accumulator minus the product. In every case only the low W bits of the arithmetic are kept, so the same hardware serves signed and unsigned operands and the unit has no signedness control.

An external condition evaluator supplies a pass signal. When the condition fails, the operation leaves no trace: no register write and no flag change. The current flags enter the unit, and the next flag values leave it. Only the plain multiply may refresh flags, and then only negative and zero. Carry and overflow always pass through unchanged.

The unit samples its inputs on `valid_i`. One clock later it presents the result, the write enable and the next flags, together with `valid_o`.

Top module: `mac_unit`

## Requirements
- R1: With op_i = 2'b00 and the condition passing, result_o equals the low 32 bits of opa_i × opb_i and wr_en_o is 1.
- R2: With op_i = 2'b01 and the condition passing, result_o equals the low 32 bits of (opa_i × opb_i) + acc_i and wr_en_o is 1.
- R3: With op_i = 2'b10 and the condition passing, result_o equals the low 32 bits of acc_i − (opa_i × opb_i) and wr_en_o is 1.
- R4: Operands read as two's-complement negative values give the same low 32 bits as the signed product, sum or difference.
- R5: For op_i = 2'b00 with set_flags_i = 1 and the condition passing, flags_o[3] (negative) equals result bit 31 and flags_o[2] (zero) is 1 only when the whole result is zero.
- R6: flags_o[1] (carry) and flags_o[0] (overflow) always equal flags_i[1:0] as sampled with the operation, including when set_flags_i is 1.
- R7: For op_i = 2'b01 or 2'b10, flags_o equals flags_i as sampled, whatever the value of set_flags_i.
- R8: With cond_pass_i = 0, wr_en_o is 0 and flags_o equals flags_i as sampled, for every op_i.
- R9: op_i = 2'b11 is reserved: wr_en_o is 0 and flags_o equals flags_i as sampled.
- R10: valid_o is 1 exactly in the cycle after a cycle with valid_i = 1, and wr_en_o is never 1 without valid_o.
- R11: While rst_ni is low, valid_o and wr_en_o are 0 and flags_o is 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe; inputs are sampled while high |
| op_i | input | 2 | 00 multiply, 01 multiply-add, 10 accumulator minus product, 11 reserved |
| opa_i | input | 32 | First multiplicand |
| opb_i | input | 32 | Second multiplicand |
| acc_i | input | 32 | Accumulator operand |
| set_flags_i | input | 1 | Request negative/zero update (plain multiply only) |
| cond_pass_i | input | 1 | Condition evaluator result; 0 cancels the operation |
| flags_i | input | 4 | Current flags {N, Z, C, V} |
| valid_o | output | 1 | Output strobe, one cycle after valid_i |
| result_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Destination register write enable |
| flags_o | output | 4 | Next flags {N, Z, C, V} |

## Verification
The assertions assume that valid_i is low throughout reset and that every input is stable and known when valid_i is high. They also assume that the flags presented with an operation are the ones that the outputs must reproduce one cycle later. The stimulus drives all inputs away from the clock edge and holds valid_i low during reset. Its random operations cover every op_i code, both settings of set_flags_i and cond_pass_i, and arbitrary flag inputs. Directed cases add a zero product, a negative product, wrap-around and signed operands.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    OP_MUL = 2'b00,
    OP_MAD = 2'b01,
    OP_MSB = 2'b10,
    OP_RSV = 2'b11
  } mac_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/mac_arith.sv
module mac_arith
  import mac_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  mac_op_e        op_i,
  input  logic [W-1:0]   opa_i,
  input  logic [W-1:0]   opb_i,
  input  logic [W-1:0]   acc_i,
  output logic [W-1:0]   result_o
);
  // low W bits only: identical for signed and unsigned operands
  logic [W-1:0] prod;
  assign prod = opa_i * opb_i;

  always_comb begin
    unique case (op_i)
      OP_MAD:  result_o = prod + acc_i;
      OP_MSB:  result_o = acc_i - prod;
      default: result_o = prod;
    endcase
  end
endmodule

// File: rtl/mac_flags.sv
module mac_flags
  import mac_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  mac_op_e      op_i,
  input  logic         set_flags_i,
  input  logic         cond_pass_i,
  input  flags_t       flags_i,
  input  logic [W-1:0] result_i,
  output logic         wr_en_o,
  output flags_t       flags_o
);
  logic legal_op;
  assign legal_op = (op_i != OP_RSV);
  assign wr_en_o  = cond_pass_i && legal_op;

  always_comb begin
    flags_o = flags_i;
    if (cond_pass_i && set_flags_i && op_i == OP_MUL) begin
      flags_o.n = result_i[W-1];
      flags_o.z = ~|result_i;
    end
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic [W-1:0] acc_i,
  input  logic         set_flags_i,
  input  logic         cond_pass_i,
  input  logic [3:0]   flags_i,
  output logic         valid_o,
  output logic [W-1:0] result_o,
  output logic         wr_en_o,
  output logic [3:0]   flags_o
);
  mac_op_e      op;
  logic [W-1:0] result_d;
  logic         wr_en_d;
  flags_t       flags_d;

  assign op = mac_op_e'(op_i);

  mac_arith #(.W(W)) u_arith (
    .op_i     (op),
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .acc_i    (acc_i),
    .result_o (result_d)
  );

  mac_flags #(.W(W)) u_flags (
    .op_i        (op),
    .set_flags_i (set_flags_i),
    .cond_pass_i (cond_pass_i),
    .flags_i     (flags_t'(flags_i)),
    .result_i    (result_d),
    .wr_en_o     (wr_en_d),
    .flags_o     (flags_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      wr_en_o  <= 1'b0;
      result_o <= '0;
      flags_o  <= '0;
    end else begin
      valid_o <= valid_i;
      wr_en_o <= valid_i && wr_en_d;
      if (valid_i) begin
        result_o <= result_d;
        flags_o  <= flags_d;
      end
    end
  end
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [1:0]   op_i,
  input logic [W-1:0] opa_i,
  input logic [W-1:0] opb_i,
  input logic [W-1:0] acc_i,
  input logic         set_flags_i,
  input logic         cond_pass_i,
  input logic [3:0]   flags_i,
  input logic         valid_o,
  input logic [W-1:0] result_o,
  input logic         wr_en_o,
  input logic [3:0]   flags_o
);
  // R1
  mul_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cond_pass_i && op_i == 2'b00) |=>
      (wr_en_o && result_o == W'($past(opa_i) * $past(opb_i))));

  // R2
  mad_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cond_pass_i && op_i == 2'b01) |=>
      (wr_en_o && result_o == W'($past(opa_i) * $past(opb_i) + $past(acc_i))));

  // R3
  msb_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cond_pass_i && op_i == 2'b10) |=>
      (wr_en_o && result_o == W'($past(acc_i) - $past(opa_i) * $past(opb_i))));

  // R5
  nz_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cond_pass_i && set_flags_i && op_i == 2'b00) |=>
      (flags_o[3] == result_o[W-1] && flags_o[2] == (result_o == '0)));

  // R6
  cv_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (flags_o[1:0] == $past(flags_i[1:0])));

  // R7
  acc_flags_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 2'b01 || op_i == 2'b10)) |=> (flags_o == $past(flags_i)));

  // R8
  cond_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !cond_pass_i) |=> (!wr_en_o && flags_o == $past(flags_i)));

  // R9
  rsv_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b11) |=> (!wr_en_o && flags_o == $past(flags_i)));

  // R10
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R10
  valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  // R10
  wr_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> valid_o);
endmodule

bind mac_unit mac_unit_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .op_i        (op_i),
  .opa_i       (opa_i),
  .opb_i       (opb_i),
  .acc_i       (acc_i),
  .set_flags_i (set_flags_i),
  .cond_pass_i (cond_pass_i),
  .flags_i     (flags_i),
  .valid_o     (valid_o),
  .result_o    (result_o),
  .wr_en_o     (wr_en_o),
  .flags_o     (flags_o)
);

// File: tb/mac_unit_bench.sv
`timescale 1ns/1ps
module mac_unit_bench;
  localparam int unsigned W = 32;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [1:0]   op_i = '0;
  logic [W-1:0] opa_i = '0, opb_i = '0, acc_i = '0;
  logic         set_flags_i = 1'b0, cond_pass_i = 1'b0;
  logic [3:0]   flags_i = '0;
  logic         valid_o, wr_en_o;
  logic [W-1:0] result_o;
  logic [3:0]   flags_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  mac_unit #(.W(W)) u_mac_unit (
    .clk_i, .rst_ni, .valid_i, .op_i, .opa_i, .opb_i, .acc_i,
    .set_flags_i, .cond_pass_i, .flags_i,
    .valid_o, .result_o, .wr_en_o, .flags_o
  );

  function automatic logic [W-1:0] exp_result(logic [1:0] op, logic [W-1:0] a,
                                             logic [W-1:0] b, logic [W-1:0] c);
    logic [2*W-1:0] full;
    full = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    case (op)
      2'b01:   return full[W-1:0] + c;
      2'b10:   return c - full[W-1:0];
      default: return full[W-1:0];
    endcase
  endfunction

  function automatic logic [3:0] exp_flags(logic [1:0] op, logic sf, logic cp,
                                           logic [3:0] f, logic [W-1:0] r);
    if (cp && sf && op == 2'b00) return {r[W-1], r == '0, f[1:0]};
    return f;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one operation; outputs sampled on the negedge after the capturing posedge
  task automatic run_op(string req, logic [1:0] op, logic [W-1:0] a, logic [W-1:0] b,
                        logic [W-1:0] c, logic sf, logic cp, logic [3:0] f);
    logic [W-1:0] er;
    logic ew;
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; opa_i = a; opb_i = b; acc_i = c;
    set_flags_i = sf; cond_pass_i = cp; flags_i = f;
    er = exp_result(op, a, b, c);
    ew = cp && (op != 2'b11);
    @(negedge clk_i);
    valid_i = 1'b0;
    check({req, " R10 valid"}, 64'(valid_o), 64'd1);
    check({req, " wr_en"}, 64'(wr_en_o), 64'(ew));
    if (ew) check({req, " result"}, 64'(result_o), 64'(er));
    check({req, " flags R6"}, 64'(flags_o), 64'(exp_flags(op, sf, cp, f, er)));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    // R11: reset state
    check("R11 valid_o", 64'(valid_o), 64'd0);
    check("R11 wr_en_o", 64'(wr_en_o), 64'd0);
    check("R11 flags_o", 64'(flags_o), 64'd0);
    rst_ni = 1'b1;

    // directed
    run_op("R1 basic", 2'b00, 32'd7, 32'd6, 32'd0, 1'b0, 1'b1, 4'b0011);
    run_op("R1 wrap", 2'b00, 32'hFFFF_FFFF, 32'h1234_5678, 32'd0, 1'b0, 1'b1, 4'b0000);
    run_op("R2 acc", 2'b01, 32'd100, 32'd3, 32'd5, 1'b0, 1'b1, 4'b1010);
    run_op("R2 wrap", 2'b01, 32'h8000_0000, 32'd2, 32'h0000_0009, 1'b0, 1'b1, 4'b0000);
    run_op("R3 sub", 2'b10, 32'd4, 32'd5, 32'd50, 1'b0, 1'b1, 4'b0101);
    run_op("R3 negative", 2'b10, 32'd9, 32'd9, 32'd1, 1'b0, 1'b1, 4'b0000);
    // R4: -3 * 5 = -15 ; -7 * -7 = 49
    run_op("R4 signed", 2'b00, 32'hFFFF_FFFD, 32'd5, 32'd0, 1'b0, 1'b1, 4'b0000);
    check("R4 value", 64'(result_o), 64'(32'hFFFF_FFF1));
    run_op("R4 signed2", 2'b01, 32'hFFFF_FFF9, 32'hFFFF_FFF9, 32'hFFFF_FFFF, 1'b0, 1'b1, 4'b0000);
    check("R4 value2", 64'(result_o), 64'd48);
    // R5: zero and negative flags
    run_op("R5 zero", 2'b00, 32'd0, 32'hABCD, 32'd0, 1'b1, 1'b1, 4'b1011);
    check("R5 Z set", 64'(flags_o), 64'(4'b0111));
    run_op("R5 neg", 2'b00, 32'hFFFF_FFFF, 32'd1, 32'd0, 1'b1, 1'b1, 4'b0100);
    check("R5 N set", 64'(flags_o), 64'(4'b1000));
    run_op("R5 wrap zero", 2'b00, 32'h0001_0000, 32'h0001_0000, 32'd0, 1'b1, 1'b1, 4'b0001);
    // R7: flag request ignored for acc/sub
    run_op("R7 mad", 2'b01, 32'd0, 32'd0, 32'd0, 1'b1, 1'b1, 4'b1111);
    run_op("R7 msb", 2'b10, 32'd1, 32'd1, 32'd1, 1'b1, 1'b1, 4'b1001);
    // R8: condition fails
    run_op("R8 mul", 2'b00, 32'd0, 32'd0, 32'd0, 1'b1, 1'b0, 4'b1110);
    run_op("R8 mad", 2'b01, 32'd3, 32'd3, 32'd3, 1'b0, 1'b0, 4'b0110);
    // R9: reserved
    run_op("R9 rsv", 2'b11, 32'd0, 32'd0, 32'd0, 1'b1, 1'b1, 4'b1100);
    // R10: valid drops after a gap
    @(negedge clk_i);
    check("R10 idle valid", 64'(valid_o), 64'd0);
    check("R10 idle wr_en", 64'(wr_en_o), 64'd0);

    // random
    for (int i = 0; i < 400; i++) begin
      logic [1:0] op;
      logic [W-1:0] a, b, c;
      op = 2'($urandom_range(0, 3));
      a = $urandom();
      b = (i % 5 == 0) ? 32'd0 : $urandom();
      c = $urandom();
      run_op("R1-R9 random", op, a, b, c, 1'($urandom()), ($urandom_range(0, 7) != 0),
             4'($urandom()));
      if (i % 7 == 0) begin
        @(negedge clk_i);
        check("R10 gap", 64'(valid_o), 64'd0);
      end
    end

    // R11: reset again after activity
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R11 rst valid", 64'(valid_o), 64'd0);
    check("R11 rst flags", 64'(flags_o), 64'd0);
    check("R11 rst wr_en", 64'(wr_en_o), 64'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule